// File: doc/BRIEF.md
# Manchester-Coded Sensor Bus Slave Node

This block is the digital end of one slave on a two-wire, single-master sensor bus that runs at a low bit rate. The master sends Manchester-coded frames. The node recovers each bit cell and builds a 16-bit frame from it: a 5-bit destination address, a 3-bit command and an 8-bit data byte. It checks the address against its own programmed address and against the all-slaves broadcast value, then passes each accepted command to a local port as a single-cycle pulse.

When the master addresses this node alone with a read command, the node forms a reply frame. The reply carries its own address, the command and a byte taken from the local side. The node splits the reply into bits, Manchester-encodes them and drives them onto its transmit wire. A one-entry holding register keeps a reply that arrives while an earlier reply is still being sent, so that reply is not lost.

The recovered bit timing comes from a divider. One half-cell lasts `HALF_CLKS` system clocks.

Top module: `mbs_bus_slave`

## Requirements
- R1: Line coding. A 1 is sent high then low and a 0 is sent low then high, and each half-cell lasts HALF_CLKS clocks. A frame is one start cell carrying 1, followed by 16 cells sent most significant bit first: address[15:11], command[10:8], data[7:0]. The idle line is low.
- R2: A frame whose address equals `node_addr` gives exactly one `cmd_valid` pulse. The pulse carries the frame's command and data, with `cmd_bcast` = 0.
- R3: A frame addressed to any other non-broadcast value gives no `cmd_valid` pulse and no reply.
- R4: A frame with address 5'b11111 is accepted by every node and gives one `cmd_valid` pulse with `cmd_bcast` = 1.
- R5: The node never transmits in answer to a broadcast frame, whatever its command.
- R6: A frame with the node's own address and command 3'b001 (read) gives a reply frame on `bus_tx`. The reply contains `node_addr`, command 3'b001 and the `rsp_data` value present when the command is accepted.
- R7: A cell whose two halves are at the same level raises `code_err` for one cycle, and that frame produces no `cmd_valid`.
- R8: After the line has been low for at least three half-cells, the decoder is armed again, and the next frame is decoded normally. This holds after a coding error as well.
- R9: After reset, `bus_tx`, `cmd_valid` and `code_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_addr | input | 5 | Programmed slave address |
| bus_rx | input | 1 | Manchester-coded line from the master |
| bus_tx | output | 1 | Manchester-coded reply line, low when idle |
| code_err | output | 1 | One-cycle pulse when a cell has no mid-cell transition |
| cmd_valid | output | 1 | One-cycle pulse for each accepted command |
| cmd_code | output | 3 | Command of the accepted frame |
| cmd_data | output | 8 | Data byte of the accepted frame |
| cmd_bcast | output | 1 | Accepted frame used the broadcast address |
| rsp_data | input | 8 | Byte returned in a read reply |

## Verification
The bench drives frames to the node's own address, to a foreign address and to the broadcast address. This separates address matching from broadcast acceptance, and shows that a read reply goes out only for a match on the node's own address. Data bytes of 00, FF, A5 and 3C exercise long runs and alternating cells, so a bit-order or polarity fault shows up in either the decoded fields or the reply. A frame with a flat final cell checks error detection. The frames sent after it, including one with a changed programmed address, check that the decoder re-arms and that address filtering follows `node_addr`.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
   localparam int ADDR_W  = 5;
   localparam int CMD_W   = 3;
   localparam int DATA_W  = 8;
   localparam int FRAME_W = ADDR_W + CMD_W + DATA_W;
   localparam int CELLS   = FRAME_W + 1;
   localparam logic [ADDR_W-1:0] ADDR_ALL = '1;
   localparam logic [CMD_W-1:0]  CMD_READ = 3'b001;

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic [CMD_W-1:0]  cmd;
      logic [DATA_W-1:0] data;
   } frame_t;
endpackage

// File: rtl/mbs_rx_decoder.sv
module mbs_rx_decoder
   import mbs_pkg::*;
#(
   parameter int HALF_CLKS   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   rx_line,
   output logic   frame_valid,
   output frame_t frame_out,
   output logic   code_err
);
   localparam int QUIET_CLKS = 3 * HALF_CLKS;
   localparam int CW         = $clog2(QUIET_CLKS + 1);
   localparam int HW         = $clog2(2 * CELLS);
   localparam int SAMPLE_AT  = HALF_CLKS / 2;

   typedef enum logic [1:0] {D_QUIET, D_ARMED, D_RUN} dstate_t;

   logic           rx_s, rx_d, first_h;
   dstate_t        st;
   logic [CW-1:0]  cnt;
   logic [HW-1:0]  hidx;
   logic [CELLS-1:0] sh;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign rx_s = rx_line;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] ff;
      always_ff @(posedge clk) begin
         if (!rst_n) ff <= '0;
         else        ff <= (ff << 1) | SYNC_STAGES'(rx_line);
      end
      assign rx_s = ff[SYNC_STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= D_QUIET;
         rx_d        <= 1'b0;
         cnt         <= '0;
         hidx        <= '0;
         first_h     <= 1'b0;
         sh          <= '0;
         frame_valid <= 1'b0;
         code_err    <= 1'b0;
      end else begin
         frame_valid <= 1'b0;
         code_err    <= 1'b0;
         rx_d        <= rx_s;
         case (st)
            D_QUIET: begin
               if (rx_s)                        cnt <= '0;
               else if (cnt == CW'(QUIET_CLKS - 1)) st <= D_ARMED;
               else                             cnt <= cnt + 1'b1;
            end
            D_ARMED: begin
               if (rx_s && !rx_d) begin
                  st   <= D_RUN;
                  cnt  <= CW'(1);
                  hidx <= '0;
               end
            end
            default: begin
               if (cnt == CW'(HALF_CLKS - 1)) begin
                  cnt  <= '0;
                  hidx <= hidx + 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
               if (cnt == CW'(SAMPLE_AT)) begin
                  if (!hidx[0]) begin
                     first_h <= rx_s;
                  end else if (rx_s == first_h) begin
                     code_err <= 1'b1;
                     st       <= D_QUIET;
                     cnt      <= '0;
                  end else begin
                     sh <= {sh[CELLS-2:0], first_h};
                     if (hidx == HW'(2 * CELLS - 1)) begin
                        frame_valid <= 1'b1;
                        st          <= D_QUIET;
                        cnt         <= '0;
                     end
                  end
               end
            end
         endcase
      end
   end

   assign frame_out = frame_t'(sh[FRAME_W-1:0]);

   // R7
   err_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      code_err |-> $past(st) == D_RUN && !frame_valid)
      else $error("coding error raised outside a frame");

   // R8
   frame_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> $past(st) == D_RUN && st == D_QUIET)
      else $error("frame completed outside a run");
endmodule

// File: rtl/mbs_frame_filter.sv
module mbs_frame_filter
   import mbs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] node_addr,
   input  logic              frame_valid,
   input  frame_t            frame_in,
   input  logic [DATA_W-1:0] rsp_data,
   output logic              cmd_valid,
   output logic [CMD_W-1:0]  cmd_code,
   output logic [DATA_W-1:0] cmd_data,
   output logic              cmd_bcast,
   output logic              reply_go,
   output frame_t            reply_frame
);
   logic hit_own, hit_all;
   assign hit_all = (frame_in.addr == ADDR_ALL);
   assign hit_own = (frame_in.addr == node_addr) && !hit_all;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_valid   <= 1'b0;
         cmd_code    <= '0;
         cmd_data    <= '0;
         cmd_bcast   <= 1'b0;
         reply_go    <= 1'b0;
         reply_frame <= '0;
      end else begin
         cmd_valid <= frame_valid && (hit_own || hit_all);
         reply_go  <= frame_valid && hit_own && (frame_in.cmd == CMD_READ);
         if (frame_valid && (hit_own || hit_all)) begin
            cmd_code  <= frame_in.cmd;
            cmd_data  <= frame_in.data;
            cmd_bcast <= hit_all;
            reply_frame <= '{addr: node_addr, cmd: frame_in.cmd, data: rsp_data};
         end
      end
   end

   // R2
   cmd_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(frame_valid))
      else $error("command pulse without a decoded frame");

   // R5
   no_bcast_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reply_go |-> cmd_valid && !cmd_bcast)
      else $error("reply requested for a broadcast frame");
endmodule

// File: rtl/mbs_tx_encoder.sv
module mbs_tx_encoder
   import mbs_pkg::*;
#(
   parameter int HALF_CLKS = 4
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   go,
   input  frame_t frame_in,
   output logic   tx_line,
   output logic   tx_busy
);
   localparam int CW = $clog2(HALF_CLKS + 1);
   localparam int HW = $clog2(2 * CELLS);

   logic             pend_v;
   frame_t           pend;
   logic [CELLS-1:0] sh;
   logic [CW-1:0]    cnt;
   logic [HW-1:0]    hidx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_busy <= 1'b0;
         pend_v  <= 1'b0;
         pend    <= '0;
         sh      <= '0;
         cnt     <= '0;
         hidx    <= '0;
      end else begin
         if (tx_busy) begin
            if (cnt == CW'(HALF_CLKS - 1)) begin
               cnt <= '0;
               if (hidx == HW'(2 * CELLS - 1)) begin
                  tx_busy <= 1'b0;
               end else begin
                  hidx <= hidx + 1'b1;
                  if (hidx[0]) sh <= sh << 1;
               end
            end else begin
               cnt <= cnt + 1'b1;
            end
            if (go) begin
               pend   <= frame_in;
               pend_v <= 1'b1;
            end
         end else if (pend_v) begin
            tx_busy <= 1'b1;
            sh      <= {1'b1, pend};
            cnt     <= '0;
            hidx    <= '0;
            pend_v  <= go;
            if (go) pend <= frame_in;
         end else if (go) begin
            tx_busy <= 1'b1;
            sh      <= {1'b1, frame_in};
            cnt     <= '0;
            hidx    <= '0;
         end
      end
   end

   assign tx_line = tx_busy && (sh[CELLS-1] ^ hidx[0]);

   // R1
   mid_cell_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_busy && cnt == '0 && hidx[0]) |-> tx_line != $past(tx_line))
      else $error("reply cell without mid-cell transition");
endmodule

// File: rtl/mbs_bus_slave.sv
module mbs_bus_slave
   import mbs_pkg::*;
#(
   parameter int HALF_CLKS   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] node_addr,
   input  logic              bus_rx,
   output logic              bus_tx,
   output logic              code_err,
   output logic              cmd_valid,
   output logic [CMD_W-1:0]  cmd_code,
   output logic [DATA_W-1:0] cmd_data,
   output logic              cmd_bcast,
   input  logic [DATA_W-1:0] rsp_data
);
   if (HALF_CLKS < 2) begin : g_bad_half
      $error("HALF_CLKS must be at least 2");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must be 0 to 4");
   end

   logic   frame_valid, reply_go, tx_busy;
   frame_t rx_frame, reply_frame;

   mbs_rx_decoder #(.HALF_CLKS(HALF_CLKS), .SYNC_STAGES(SYNC_STAGES)) u_dec (
      .clk(clk), .rst_n(rst_n), .rx_line(bus_rx),
      .frame_valid(frame_valid), .frame_out(rx_frame), .code_err(code_err));

   mbs_frame_filter u_filt (
      .clk(clk), .rst_n(rst_n), .node_addr(node_addr),
      .frame_valid(frame_valid), .frame_in(rx_frame), .rsp_data(rsp_data),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_data(cmd_data),
      .cmd_bcast(cmd_bcast), .reply_go(reply_go), .reply_frame(reply_frame));

   mbs_tx_encoder #(.HALF_CLKS(HALF_CLKS)) u_enc (
      .clk(clk), .rst_n(rst_n), .go(reply_go), .frame_in(reply_frame),
      .tx_line(bus_tx), .tx_busy(tx_busy));

   // R9
   idle_after_reset_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> !bus_tx && !cmd_valid && !code_err)
      else $error("outputs active right after reset");

   // R5
   bcast_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_bcast) |=> !$rose(tx_busy))
      else $error("transmission started after broadcast");
endmodule

// File: tb/test_mbs_bus_slave.sv
module test_mbs_bus_slave;
   localparam int HALF = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] node_addr = 5'd9;
   logic       bus_rx = 1'b0;
   logic       bus_tx, code_err, cmd_valid, cmd_bcast;
   logic [2:0] cmd_code;
   logic [7:0] cmd_data, rsp_data = 8'h00;

   int n_chk = 0, n_fail = 0, n_err = 0;
   logic [11:0] exp_q[$];

   always #4 clk = ~clk;

   mbs_bus_slave #(.HALF_CLKS(HALF), .SYNC_STAGES(2)) i_mbs_bus_slave (
      .clk(clk), .rst_n(rst_n), .node_addr(node_addr), .bus_rx(bus_rx),
      .bus_tx(bus_tx), .code_err(code_err), .cmd_valid(cmd_valid),
      .cmd_code(cmd_code), .cmd_data(cmd_data), .cmd_bcast(cmd_bcast),
      .rsp_data(rsp_data));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // reference model: every command pulse must match the next expected entry
   always @(negedge clk) begin
      if (rst_n && code_err) n_err++;
      if (rst_n && cmd_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R3 unexpected command pulse", {cmd_bcast, cmd_code, cmd_data}, 0);
         end else begin
            logic [11:0] e;
            e = exp_q.pop_front();
            chk({cmd_bcast, cmd_code, cmd_data} == e, "R2/R4 command fields",
                {cmd_bcast, cmd_code, cmd_data}, e);
         end
      end
   end

   task automatic send_frame(input logic [4:0] a, input logic [2:0] c,
                             input logic [7:0] d, input bit bad);
      logic [16:0] bits;
      bits = {1'b1, a, c, d};
      for (int i = 16; i >= 0; i--) begin
         for (int h = 0; h < 2; h++) begin
            bus_rx = (bad && i == 0) ? 1'b1 : (h == 0 ? bits[i] : ~bits[i]);
            repeat (HALF) @(negedge clk);
         end
      end
      bus_rx = 1'b0;
   endtask

   task automatic get_reply(output logic [16:0] got, output bit seen, output bit coded);
      seen = 0; coded = 1; got = '0;
      for (int k = 0; k < 60 && !seen; k++) begin
         @(negedge clk);
         if (bus_tx) seen = 1;
      end
      if (seen) begin
         repeat (HALF / 2) @(negedge clk);
         for (int c = 16; c >= 0; c--) begin
            logic f;
            f = bus_tx;
            repeat (HALF) @(negedge clk);
            if (bus_tx == f) coded = 0;
            got[c] = f;
            repeat (HALF) @(negedge clk);
         end
      end
   endtask

   task automatic quiet_check(input string tag);
      bit hi = 0;
      for (int k = 0; k < 80; k++) begin
         @(negedge clk);
         if (bus_tx) hi = 1;
      end
      chk(!hi, tag, hi, 0);
   endtask

   task automatic settle(input string tag);
      repeat (40) @(negedge clk);
      chk(exp_q.size() == 0, tag, exp_q.size(), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [16:0] rep;
      bit seen, coded;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(!bus_tx && !cmd_valid && !code_err, "R9 reset outputs",
          {bus_tx, cmd_valid, code_err}, 0);
      repeat (20) @(negedge clk);

      // R2 own address write
      exp_q.push_back({1'b0, 3'd2, 8'hA5});
      send_frame(5'd9, 3'd2, 8'hA5, 0);
      quiet_check("R6 no reply to non-read");
      settle("R2 own frame accepted");

      // R3 foreign address, read command
      send_frame(5'd3, 3'd1, 8'h77, 0);
      quiet_check("R3 no reply to foreign address");
      settle("R3 foreign ignored");

      // R4/R5 broadcast read
      exp_q.push_back({1'b1, 3'd1, 8'hFF});
      send_frame(5'd31, 3'd1, 8'hFF, 0);
      quiet_check("R5 silent after broadcast");
      settle("R4 broadcast accepted");

      // R6 own read with reply, R1 reply coding
      rsp_data = 8'h3C;
      exp_q.push_back({1'b0, 3'd1, 8'h00});
      send_frame(5'd9, 3'd1, 8'h00, 0);
      get_reply(rep, seen, coded);
      chk(seen, "R6 reply present", seen, 1);
      chk(rep == {1'b1, 5'd9, 3'd1, 8'h3C}, "R6 reply contents", rep, {1'b1, 5'd9, 3'd1, 8'h3C});
      chk(coded, "R1 reply mid-cell transitions", coded, 1);
      rsp_data = 8'h00;
      settle("R6 read command pulse");

      // R7 coding error
      send_frame(5'd9, 3'd4, 8'h5A, 1);
      repeat (40) @(negedge clk);
      chk(n_err == 1, "R7 coding error flagged", n_err, 1);
      settle("R7 frame discarded");

      // R8 recovery after error
      exp_q.push_back({1'b0, 3'd7, 8'hFF});
      send_frame(5'd9, 3'd7, 8'hFF, 0);
      settle("R8 decode after error");

      // R2 with changed programmed address and second reply
      node_addr = 5'd0;
      rsp_data  = 8'hC3;
      send_frame(5'd9, 3'd1, 8'h11, 0);
      quiet_check("R3 old address ignored");
      exp_q.push_back({1'b0, 3'd1, 8'h81});
      send_frame(5'd0, 3'd1, 8'h81, 0);
      get_reply(rep, seen, coded);
      chk(rep == {1'b1, 5'd0, 3'd1, 8'hC3}, "R6 reply for address 0", rep, {1'b1, 5'd0, 3'd1, 8'hC3});
      chk(coded, "R1 second reply coding", coded, 1);
      settle("R2 new address accepted");
      chk(n_err == 1, "R7 no spurious errors", n_err, 1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule